// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit with Private High/Low Result Registers

This block performs integer multiplication and division on two operands of `W` bits (32 by default). It keeps its results in two private registers, a high word and a low word. A multiply places the upper half of the double-width product in the high word and the lower half in the low word. A divide places the quotient in the low word and the remainder in the high word. A separate three-operand multiply returns only the low half of the product, straight on the result port, and leaves both private registers as they were.

A pipeline issues an operation by pulsing `start_i` together with an operation code and two operands while `busy_o` is low. The unit then works bit by bit: one shift-add step per cycle for a multiply, one shift-subtract step per cycle for a divide. Sign correction follows in a final cycle. The register file gets its words back through move reads: `rd_req_i` with `rd_sel_i` selects the high or the low word. A move read made while the unit is busy waits until the operation has finished and the new values are in place.

Top module: `muldiv_unit`

## Requirements
- R1: After reset `busy_o` and `out_valid_o` are low, and move reads of both the high and the low word return zero.
- R2: Operation code 0 (signed multiply) leaves the upper W bits of the two's-complement product of the operands in the high word and the lower W bits in the low word.
- R3: Operation code 1 (unsigned multiply) leaves the upper and lower halves of the unsigned product in the high and low words.
- R4: Operation code 2 (signed divide) leaves in the low word the quotient rounded toward zero. It leaves in the high word the remainder, which carries the sign of the dividend. The most negative dividend divided by -1 gives a quotient equal to the most negative value.
- R5: Operation code 3 (unsigned divide) leaves the unsigned quotient in the low word and the unsigned remainder in the high word.
- R6: A divide (code 2 or 3) with a zero divisor finishes in the normal time. It leaves all ones in the low word and the unchanged dividend in the high word.
- R7: Operation code 4 (low-word multiply) pulses `out_valid_o` for one cycle on the cycle `busy_o` falls, with the lower W bits of the product on `out_data_o`. It leaves the high and low words unchanged.
- R8: An accepted start raises `busy_o` in the next cycle, and `busy_o` stays high for exactly W+1 cycles (33 by default).
- R9: With `busy_o` low, a move read (`rd_req_i` high, `rd_sel_i` 1 for high and 0 for low) gives `out_valid_o` high in the next cycle, with the selected word on `out_data_o`.
- R10: A move read held while `busy_o` is high gives no `out_valid_o` until `busy_o` has fallen. It is then served with the words the operation produced.
- R11: A start made while `busy_o` is high, or a start with an operation code from 5 to 7, is ignored: `busy_o` does not change because of it, and the high and low words keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Issue an operation this cycle |
| op_i | input | 3 | Operation code (0 signed mul, 1 unsigned mul, 2 signed div, 3 unsigned div, 4 low-word mul) |
| opa_i | input | W | First operand (multiplicand or dividend) |
| opb_i | input | W | Second operand (multiplier or divisor) |
| busy_o | output | 1 | Operation in progress |
| rd_req_i | input | 1 | Move-read request |
| rd_sel_i | input | 1 | Move-read select: 1 high word, 0 low word |
| out_valid_o | output | 1 | `out_data_o` carries a returned word this cycle |
| out_data_o | output | W | Returned word (move read or low-word multiply result) |

## Verification
The bench builds the unit at its default width of 32 bits. At that width the extreme operand values can be written directly: the most negative number times itself, all ones times all ones, and the most negative number divided by -1. Each of these pushes the carry of the shift-add engine and the sign correction to their limits. At this width the iteration count also sets the busy window to 33 cycles. Move reads held across that window, and starts made part-way through it, therefore test the stall and ignore rules at their full length.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

   typedef enum logic [2:0] {
      OP_MULS  = 3'd0,
      OP_MULU  = 3'd1,
      OP_DIVS  = 3'd2,
      OP_DIVU  = 3'd3,
      OP_MULLO = 3'd4
   } mdu_op_e;

   function automatic logic op_legal(input logic [2:0] op);
      return op <= 3'd4;
   endfunction

   function automatic logic op_signed(input logic [2:0] op);
      return (op == OP_MULS) || (op == OP_DIVS);
   endfunction

   function automatic logic op_is_div(input logic [2:0] op);
      return (op == OP_DIVS) || (op == OP_DIVU);
   endfunction

endpackage

// File: rtl/mdu_mul_core.sv
module mdu_mul_core #(
   parameter int W = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load_i,
   input  logic           step_i,
   input  logic [W-1:0]   mcand_i,
   input  logic [W-1:0]   mplier_i,
   output logic [2*W-1:0] prod_o
);

   logic [W-1:0]   mcand_q;
   logic [2*W-1:0] prod_q;
   logic [W:0]     sum;

   always_comb begin
      sum = {1'b0, prod_q[2*W-1:W]} + (prod_q[0] ? {1'b0, mcand_q} : '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcand_q <= '0;
         prod_q  <= '0;
      end else if (load_i) begin
         mcand_q <= mcand_i;
         prod_q  <= {{W{1'b0}}, mplier_i};
      end else if (step_i) begin
         prod_q  <= {sum, prod_q[W-1:1]};
      end
   end

   assign prod_o = prod_q;

endmodule

// File: rtl/mdu_div_core.sv
module mdu_div_core #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic         step_i,
   input  logic [W-1:0] dvnd_i,
   input  logic [W-1:0] dvsr_i,
   output logic [W-1:0] quo_o,
   output logic [W-1:0] rem_o
);

   logic [W-1:0] rem_q, quo_q, dvsr_q;
   logic [W:0]   shifted;
   logic [W+1:0] diff;

   always_comb begin
      shifted = {rem_q, quo_q[W-1]};
      diff    = {1'b0, shifted} - {2'b00, dvsr_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         quo_q  <= '0;
         dvsr_q <= '0;
      end else if (load_i) begin
         rem_q  <= '0;
         quo_q  <= dvnd_i;
         dvsr_q <= dvsr_i;
      end else if (step_i) begin
         if (!diff[W+1]) begin
            rem_q <= diff[W-1:0];
            quo_q <= {quo_q[W-2:0], 1'b1};
         end else begin
            rem_q <= shifted[W-1:0];
            quo_q <= {quo_q[W-2:0], 1'b0};
         end
      end
   end

   assign quo_o = quo_q;
   assign rem_o = rem_q;

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic [2:0]   op_i,
   input  logic [W-1:0] opa_i,
   input  logic [W-1:0] opb_i,
   output logic         busy_o,
   input  logic         rd_req_i,
   input  logic         rd_sel_i,
   output logic         out_valid_o,
   output logic [W-1:0] out_data_o
);
   import mdu_pkg::*;

   localparam int CW = $clog2(W + 1);

   if (W < 4) begin : g_width_chk
      $error("muldiv_unit: W must be at least 4");
   end

   logic           busy_q, neg_prod_q, neg_quo_q, neg_rem_q;
   logic [CW-1:0]  cnt_q;
   logic [2:0]     op_q;
   logic [W-1:0]   hi_q, lo_q;
   logic           out_valid_q;
   logic [W-1:0]   out_data_q;

   logic           accept, sgn, step, finish;
   logic [W-1:0]   mag_a, mag_b;
   logic [2*W-1:0] prod, prod_fix;
   logic [W-1:0]   quo, rem, quo_fix, rem_fix;

   always_comb begin
      accept = start_i && !busy_q && op_legal(op_i);
      sgn    = op_signed(op_i);
      mag_a  = (sgn && opa_i[W-1]) ? -opa_i : opa_i;
      mag_b  = (sgn && opb_i[W-1]) ? -opb_i : opb_i;
      step   = busy_q && (cnt_q != '0);
      finish = busy_q && (cnt_q == '0);
   end

   mdu_mul_core #(.W(W)) mul_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (accept),
      .step_i   (step),
      .mcand_i  (mag_a),
      .mplier_i (mag_b),
      .prod_o   (prod)
   );

   mdu_div_core #(.W(W)) div_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (accept),
      .step_i (step),
      .dvnd_i (mag_a),
      .dvsr_i (mag_b),
      .quo_o  (quo),
      .rem_o  (rem)
   );

   always_comb begin
      prod_fix = neg_prod_q ? -prod : prod;
      quo_fix  = neg_quo_q  ? -quo  : quo;
      rem_fix  = neg_rem_q  ? -rem  : rem;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         cnt_q       <= '0;
         op_q        <= '0;
         neg_prod_q  <= 1'b0;
         neg_quo_q   <= 1'b0;
         neg_rem_q   <= 1'b0;
         hi_q        <= '0;
         lo_q        <= '0;
         out_valid_q <= 1'b0;
         out_data_q  <= '0;
      end else begin
         out_valid_q <= 1'b0;
         if (accept) begin
            busy_q     <= 1'b1;
            cnt_q      <= CW'(W);
            op_q       <= op_i;
            neg_prod_q <= sgn && (opa_i[W-1] ^ opb_i[W-1]);
            neg_quo_q  <= sgn && (opa_i[W-1] ^ opb_i[W-1]) && (opb_i != '0);
            neg_rem_q  <= sgn && opa_i[W-1];
         end else if (step) begin
            cnt_q <= cnt_q - 1'b1;
         end else if (finish) begin
            busy_q <= 1'b0;
            if (op_q == OP_MULLO) begin
               out_valid_q <= 1'b1;
               out_data_q  <= prod_fix[W-1:0];
            end else if (op_is_div(op_q)) begin
               hi_q <= rem_fix;
               lo_q <= quo_fix;
            end else begin
               hi_q <= prod_fix[2*W-1:W];
               lo_q <= prod_fix[W-1:0];
            end
         end
         if (rd_req_i && !busy_q) begin
            out_valid_q <= 1'b1;
            out_data_q  <= rd_sel_i ? hi_q : lo_q;
         end
      end
   end

   assign busy_o      = busy_q;
   assign out_valid_o = out_valid_q;
   assign out_data_o  = out_data_q;

endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk #(
   parameter int W = 32
) (
   input logic       clk,
   input logic       rst_n,
   input logic       start_i,
   input logic [2:0] op_i,
   input logic       busy_o,
   input logic       rd_req_i,
   input logic       out_valid_o
);

   int run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= 0;
      else        run_q <= busy_o ? run_q + 1 : 0;
   end

   // R8
   busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= W + 1);

   // R8
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> run_q == W + 1);

   // R8
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && op_i <= 3'd4) |=> busy_o);

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !(start_i && op_i <= 3'd4)) |=> !busy_o);

   // R9
   read_serve_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_i && !busy_o) |=> out_valid_o);

   // R10
   read_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && $past(busy_o)) |-> !busy_o);

endmodule

bind muldiv_unit muldiv_unit_chk #(.W(W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .op_i        (op_i),
   .busy_o      (busy_o),
   .rd_req_i    (rd_req_i),
   .out_valid_o (out_valid_o)
);

// File: tb/muldiv_unit_tb_top.sv
module muldiv_unit_tb_top;

   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic [2:0]   op_i = '0;
   logic [W-1:0] opa_i = '0, opb_i = '0;
   logic         rd_req_i = 1'b0, rd_sel_i = 1'b0;
   logic         busy_o, out_valid_o;
   logic [W-1:0] out_data_o;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   muldiv_unit #(.W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
      .opa_i(opa_i), .opb_i(opb_i), .busy_o(busy_o),
      .rd_req_i(rd_req_i), .rd_sel_i(rd_sel_i),
      .out_valid_o(out_valid_o), .out_data_o(out_data_o)
   );

   // reference model state
   bit           m_busy = 0;
   int           m_cnt = 0;
   logic [2:0]   m_op = '0;
   logic [W-1:0] m_hi = '0, m_lo = '0, m_rhi = '0, m_rlo = '0;
   bit           e_valid = 0;
   logic [W-1:0] e_data = '0;

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic compute(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
      logic [63:0] p;
      longint sa, sb;
      case (op)
         3'd0: begin
            p = {{32{a[31]}}, a} * {{32{b[31]}}, b};
            m_rhi = p[63:32]; m_rlo = p[31:0];
         end
         3'd1, 3'd4: begin
            p = {32'b0, a} * {32'b0, b};
            m_rhi = p[63:32]; m_rlo = p[31:0];
         end
         3'd2: begin
            if (b == 0) begin m_rlo = '1; m_rhi = a; end
            else begin
               sa = longint'($signed(a)); sb = longint'($signed(b));
               m_rlo = W'(sa / sb); m_rhi = W'(sa % sb);
            end
         end
         default: begin
            if (b == 0) begin m_rlo = '1; m_rhi = a; end
            else begin m_rlo = a / b; m_rhi = a % b; end
         end
      endcase
   endtask

   task automatic model_edge(input bit st, input logic [2:0] op, input logic [W-1:0] a,
                             input logic [W-1:0] b, input bit rd, input bit sel);
      bit busy_pre = m_busy;
      logic [W-1:0] hi_pre = m_hi, lo_pre = m_lo;
      e_valid = 0;
      if (busy_pre) begin
         if (m_cnt == 0) begin
            m_busy = 0;
            if (m_op == 3'd4) begin e_valid = 1; e_data = m_rlo; end
            else begin m_hi = m_rhi; m_lo = m_rlo; end
         end else m_cnt--;
      end
      if (!busy_pre && rd) begin e_valid = 1; e_data = sel ? hi_pre : lo_pre; end
      if (!busy_pre && st && op <= 3'd4) begin
         m_busy = 1; m_cnt = W; m_op = op;
         compute(op, a, b);
      end
   endtask

   // one clock: drive at negedge, model the edge, compare at next negedge
   task automatic tick(input bit st, input logic [2:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] b, input bit rd, input bit sel, input string tag);
      start_i = st; op_i = op; opa_i = a; opb_i = b; rd_req_i = rd; rd_sel_i = sel;
      @(posedge clk);
      #1;
      model_edge(st, op, a, b, rd, sel);
      @(negedge clk);
      check(busy_o == m_busy, tag, "busy", W'(busy_o), W'(m_busy));
      check(out_valid_o == e_valid, tag, "valid", W'(out_valid_o), W'(e_valid));
      if (e_valid) check(out_data_o == e_data, tag, "data", out_data_o, e_data);
   endtask

   task automatic run_op(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                         input bit hold_rd, input string tag);
      int seen = 0;
      tick(1, op, a, b, 0, 0, tag);
      if (busy_o) seen++;
      for (int i = 0; i < W + 2; i++) begin
         tick(0, 3'd0, '0, '0, hold_rd, 1, tag);
         if (busy_o) seen++;
      end
      // R8 busy window length
      check(seen == ((op <= 3'd4) ? W + 1 : 0), "R8", "busy cycles", W'(seen),
            W'((op <= 3'd4) ? W + 1 : 0));
      tick(0, 3'd0, '0, '0, 1, 1, tag);
      tick(0, 3'd0, '0, '0, 1, 0, tag);
      tick(0, 3'd0, '0, '0, 0, 0, tag);
   endtask

   initial begin
      #(8 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(busy_o == 0, "R1", "busy after reset", W'(busy_o), '0);
      check(out_valid_o == 0, "R1", "valid after reset", W'(out_valid_o), '0);
      rst_n = 1'b1;
      tick(0, 3'd0, '0, '0, 1, 1, "R1");
      tick(0, 3'd0, '0, '0, 1, 0, "R1");
      tick(0, 3'd0, '0, '0, 0, 0, "R9");

      // R2 signed multiply
      run_op(3'd0, -32'sd3, 32'd7, 0, "R2");
      run_op(3'd0, 32'h8000_0000, 32'h8000_0000, 0, "R2");
      run_op(3'd0, 32'hffff_ffff, 32'hffff_ffff, 1, "R2");
      // R3 unsigned multiply
      run_op(3'd1, 32'hffff_ffff, 32'hffff_ffff, 0, "R3");
      run_op(3'd1, 32'h1234_5678, 32'h0000_1000, 1, "R3");
      // R4 signed divide
      run_op(3'd2, -32'sd7, 32'd2, 0, "R4");
      run_op(3'd2, 32'd7, -32'sd2, 0, "R4");
      run_op(3'd2, -32'sd100, -32'sd9, 1, "R4");
      run_op(3'd2, 32'h8000_0000, 32'hffff_ffff, 0, "R4");
      // R5 unsigned divide
      run_op(3'd3, 32'hffff_ffff, 32'd3, 0, "R5");
      run_op(3'd3, 32'd100, 32'd7, 0, "R5");
      run_op(3'd3, 32'd5, 32'h8000_0000, 0, "R5");
      // R6 divide by zero
      run_op(3'd2, -32'sd5, 32'd0, 0, "R6");
      run_op(3'd3, 32'hdead_beef, 32'd0, 1, "R6");
      // R7 low-word multiply leaves hi/lo untouched
      run_op(3'd0, 32'd11, 32'd13, 0, "R7");
      run_op(3'd4, 32'h1234_5678, 32'h9abc_def0, 0, "R7");
      run_op(3'd4, 32'hffff_fffe, 32'd3, 1, "R7");
      // R10 read held through the busy window
      run_op(3'd1, 32'd65535, 32'd65537, 1, "R10");
      // R11 illegal codes ignored
      run_op(3'd6, 32'd9, 32'd9, 0, "R11");
      run_op(3'd5, 32'd1, 32'd1, 1, "R11");
      // R11 start while busy ignored
      tick(1, 3'd1, 32'd6, 32'd7, 0, 0, "R11");
      tick(0, 3'd0, '0, '0, 0, 0, "R11");
      tick(1, 3'd3, 32'd50, 32'd5, 0, 0, "R11");
      for (int i = 0; i < W + 2; i++) tick(0, 3'd0, '0, '0, 0, 0, "R11");
      tick(0, 3'd0, '0, '0, 1, 1, "R11");
      tick(0, 3'd0, '0, '0, 1, 0, "R11");
      tick(0, 3'd0, '0, '0, 0, 0, "R11");

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule